// File: doc/BRIEF.md
# Serial-Programmed Feedback Divider Control

This block owns the feedback divide ratio of a frequency-margining clock synthesizer. Software-side logic or a board controller writes a new 6-bit ratio through a three-wire port: a load-enable line, a serial clock and a serial data line. While load-enable is high, each rising serial clock edge shifts one data bit into a shift register, most significant bit first. When load-enable drops, the shifted word becomes the programmed ratio.

A mode input picks the ratio that the block presents. With mode low, the fixed nominal ratio (a parameter, 50 by default, giving 625 MHz from a 12.5 MHz reference) is used. With mode high, the programmed ratio is used. Writes are accepted in either mode. The block also contains the feedback counter itself. It divides the divider clock by the effective ratio and emits a one-cycle tick at each terminal count. Load-enable and mode pass through synchronizers into the divider clock domain, so the effective ratio changes only when the counter wraps.

Top module: `fbdiv_ctrl_top`

## Requirements
- R1: After reset, or after a later reset, the programmed ratio register holds the nominal ratio (default 50). With mode low or high, `div_value` reads the nominal ratio and `fb_tick` repeats every 50 clocks.
- R2: While `ser_load` is high, each rising edge of `ser_clk` shifts `ser_data` in at bit 0 and moves the older bits up. After six edges, the first bit sent sits in bit 5.
- R3: A high-to-low transition of `ser_load` copies the shift register into the programmed ratio register. The copy is visible on `div_value` when mode is high.
- R4: While `ser_load` is low, toggling `ser_clk` and `ser_data` changes neither the shift register nor the programmed ratio.
- R5: A write made while mode is low leaves `div_value` at the nominal ratio. The written ratio appears once mode goes high.
- R6: While `margin_en` is high, `div_value` equals the programmed ratio.
- R7: When `margin_en` returns low, `div_value` goes back to the nominal ratio, and the programmed ratio is kept.
- R8: A programmed ratio of 0 or 1 is presented as 2. The value 63 is presented unchanged.
- R9: `fb_tick` is high for one clock out of every `div_value` clocks, and `div_value` changes only in the clock right after a tick.
- R10: Reset clears the shift register. A load-enable pulse with no serial clock edges after reset commits 0, which is then presented as 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Divider clock (feedback path clock) |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| ser_load | input | 1 | Load-enable; high enables shifting, falling edge commits |
| margin_en | input | 1 | High selects the programmed ratio, low the nominal ratio |
| div_value | output | 6 | Effective feedback divide ratio |
| fb_tick | output | 1 | One-clock terminal-count tick of the feedback counter |

## Verification
The assertions assume three things about the inputs. First, the shift register is frozen whenever a committed load-enable fall reaches the divider clock domain. Second, `ser_data` is settled well before each `ser_clk` rise. Third, reset is held across several divider clocks. The stimulus meets all three: it steps the serial lines at intervals of several divider clocks, keeps `ser_clk` low around every load-enable change, and holds reset for four clocks. Mode and load changes are followed by a wait longer than the synchronizer delay plus the longest counter period before any output is compared.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
   parameter int unsigned RATIO_W   = 6;
   parameter int unsigned RATIO_MIN = 2;
   typedef logic [RATIO_W-1:0] ratio_t;

   function automatic ratio_t clamp_ratio(input ratio_t r);
      return (r < ratio_t'(RATIO_MIN)) ? ratio_t'(RATIO_MIN) : r;
   endfunction
endpackage

// File: rtl/fbdiv_sync.sv
module fbdiv_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("fbdiv_sync needs at least two stages");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= RST_VAL;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[i] <= RST_VAL;
               else        chain[i] <= chain[i-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fbdiv_shifter.sv
module fbdiv_shifter
   import fbdiv_pkg::*;
(
   input  logic   ser_clk,
   input  logic   rst_n,
   input  logic   ser_load,
   input  logic   ser_data,
   output ratio_t word
);
   // R2: msb-first, new bit enters at bit 0; R4: frozen while load is low
   always_ff @(posedge ser_clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (ser_load) word <= {word[RATIO_W-2:0], ser_data};
   end
endmodule

// File: rtl/fbdiv_ctrl_reg.sv
module fbdiv_ctrl_reg
   import fbdiv_pkg::*;
#(
   parameter int unsigned NOMINAL_M = 50
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   load_sync,
   input  ratio_t shift_word,
   output ratio_t prog_ratio
);
   logic   load_prev;
   logic   commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) load_prev <= 1'b0;
      else        load_prev <= load_sync;
   end

   assign commit = load_prev & ~load_sync;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prog_ratio <= ratio_t'(NOMINAL_M);
      else if (commit) prog_ratio <= shift_word;
   end

   assert_commit_copies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> prog_ratio == $past(shift_word));

   assert_hold_without_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(prog_ratio));
endmodule

// File: rtl/fbdiv_counter.sv
module fbdiv_counter
   import fbdiv_pkg::*;
#(
   parameter int unsigned NOMINAL_M = 50
) (
   input  logic   clk,
   input  logic   rst_n,
   input  ratio_t next_ratio,
   output ratio_t cur_ratio,
   output logic   tick
);
   ratio_t cnt;

   assign tick = (cnt == cur_ratio - ratio_t'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt       <= '0;
         cur_ratio <= ratio_t'(NOMINAL_M);
      end else if (tick) begin
         cnt       <= '0;
         cur_ratio <= next_ratio;
      end else begin
         cnt <= cnt + ratio_t'(1);
      end
   end

   assert_count_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt < cur_ratio);

   assert_ratio_changes_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(cur_ratio));

   assert_ratio_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cur_ratio >= ratio_t'(RATIO_MIN));
endmodule

// File: rtl/fbdiv_ctrl_top.sv
module fbdiv_ctrl_top
   import fbdiv_pkg::*;
#(
   parameter int unsigned NOMINAL_M   = 50,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ser_clk,
   input  logic               ser_data,
   input  logic               ser_load,
   input  logic               margin_en,
   output logic [RATIO_W-1:0] div_value,
   output logic               fb_tick
);
   localparam int unsigned MAX_RATIO = (1 << RATIO_W) - 1;

   generate
      if (NOMINAL_M < RATIO_MIN || NOMINAL_M > MAX_RATIO) begin : g_bad_nominal
         $error("NOMINAL_M outside the representable ratio range");
      end
   endgenerate

   ratio_t shift_word;
   ratio_t prog_ratio;
   ratio_t next_ratio;
   ratio_t cur_ratio;
   logic   load_sync;
   logic   mode_sync;

   fbdiv_shifter i_shift (
      .ser_clk  (ser_clk),
      .rst_n    (rst_n),
      .ser_load (ser_load),
      .ser_data (ser_data),
      .word     (shift_word)
   );

   fbdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_load (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ser_load),
      .q     (load_sync)
   );

   fbdiv_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (margin_en),
      .q     (mode_sync)
   );

   fbdiv_ctrl_reg #(.NOMINAL_M(NOMINAL_M)) i_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_sync  (load_sync),
      .shift_word (shift_word),
      .prog_ratio (prog_ratio)
   );

   // R6/R7/R8: mode picks programmed (floored) or nominal ratio
   assign next_ratio = mode_sync ? clamp_ratio(prog_ratio) : ratio_t'(NOMINAL_M);

   fbdiv_counter #(.NOMINAL_M(NOMINAL_M)) i_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .next_ratio (next_ratio),
      .cur_ratio  (cur_ratio),
      .tick       (fb_tick)
   );

   assign div_value = cur_ratio;
endmodule

// File: tb/test_fbdiv_ctrl_top.sv
`timescale 1ns/1ps
module test_fbdiv_ctrl_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_clk = 1'b0;
   logic       ser_data = 1'b0;
   logic       ser_load = 1'b0;
   logic       margin_en = 1'b0;
   logic [5:0] div_value;
   logic       fb_tick;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   fbdiv_ctrl_top i_fbdiv_ctrl_top (
      .clk       (clk),
      .rst_n     (rst_n),
      .ser_clk   (ser_clk),
      .ser_data  (ser_data),
      .ser_load  (ser_load),
      .margin_en (margin_en),
      .div_value (div_value),
      .fb_tick   (fb_tick)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (150) @(negedge clk);
   endtask

   task automatic serial_write(input logic [5:0] v);
      ser_load = 1'b1;
      #20;
      for (int i = 5; i >= 0; i--) begin
         ser_data = v[i];
         #10 ser_clk = 1'b1;
         #10 ser_clk = 1'b0;
      end
      #20 ser_load = 1'b0;
      ser_data = 1'b0;
      settle();
   endtask

   task automatic measure_period(output int n);
      n = 0;
      do @(negedge clk); while (!fb_tick);
      do begin @(negedge clk); n++; end while (!fb_tick);
   endtask

   task automatic t_reset();
      int p;
      check(div_value == 6'd50, "R1 reset ratio", div_value, 50);
      measure_period(p);
      check(p == 50, "R1/R9 reset tick period", p, 50);
      margin_en = 1'b1;
      settle();
      check(div_value == 6'd50, "R1 programmed ratio resets to nominal", div_value, 50);
      margin_en = 1'b0;
      settle();
   endtask

   task automatic t_nominal_write();
      int p;
      serial_write(6'd37);
      check(div_value == 6'd50, "R5 write in nominal mode keeps nominal", div_value, 50);
      margin_en = 1'b1;
      settle();
      check(div_value == 6'd37, "R3/R5/R6 written ratio in margin mode", div_value, 37);
      measure_period(p);
      check(p == 37, "R9 tick period 37", p, 37);
   endtask

   task automatic t_msb_first();
      int p;
      serial_write(6'b000011);
      check(div_value == 6'd3, "R2 msb-first low bits", div_value, 3);
      measure_period(p);
      check(p == 3, "R9 tick period 3", p, 3);
      serial_write(6'b110000);
      check(div_value == 6'd48, "R2 msb-first high bits", div_value, 48);
   endtask

   task automatic t_ignore_idle();
      for (int i = 0; i < 6; i++) begin
         ser_data = i[0];
         #10 ser_clk = 1'b1;
         #10 ser_clk = 1'b0;
      end
      ser_data = 1'b0;
      settle();
      check(div_value == 6'd48, "R4 idle toggles keep ratio", div_value, 48);
      ser_load = 1'b1;
      #40 ser_load = 1'b0;
      settle();
      check(div_value == 6'd48, "R4 shift register untouched by idle toggles", div_value, 48);
   endtask

   task automatic t_clamp();
      int p;
      serial_write(6'd0);
      check(div_value == 6'd2, "R8 zero presented as 2", div_value, 2);
      serial_write(6'd1);
      check(div_value == 6'd2, "R8 one presented as 2", div_value, 2);
      measure_period(p);
      check(p == 2, "R8/R9 tick period 2", p, 2);
      serial_write(6'd63);
      check(div_value == 6'd63, "R8 max ratio unchanged", div_value, 63);
      measure_period(p);
      check(p == 63, "R9 tick period 63", p, 63);
   endtask

   task automatic t_revert();
      margin_en = 1'b0;
      settle();
      check(div_value == 6'd50, "R7 revert to nominal", div_value, 50);
      margin_en = 1'b1;
      settle();
      check(div_value == 6'd63, "R7 programmed ratio kept", div_value, 63);
   endtask

   task automatic t_wrap_only();
      logic [5:0] prev_v;
      logic       prev_t;
      bit         bad = 1'b0;
      int         bad_v = 0;
      serial_write(6'd5);
      @(negedge clk);
      prev_v = div_value;
      prev_t = fb_tick;
      margin_en = 1'b0;
      for (int i = 0; i < 120; i++) begin
         @(negedge clk);
         if (div_value != prev_v && !prev_t) begin
            bad = 1'b1;
            bad_v = div_value;
         end
         prev_v = div_value;
         prev_t = fb_tick;
      end
      check(!bad, "R9 ratio changes only after tick", bad_v, 0);
      check(div_value == 6'd50, "R7/R9 nominal after mode drop", div_value, 50);
   endtask

   task automatic t_reset_shift();
      margin_en = 1'b1;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      settle();
      check(div_value == 6'd50, "R1 nominal after later reset", div_value, 50);
      ser_load = 1'b1;
      #40 ser_load = 1'b0;
      settle();
      check(div_value == 6'd2, "R10 reset cleared shift register", div_value, 2);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_nominal_write();
      t_msb_first();
      t_ignore_idle();
      t_clamp();
      t_revert();
      t_wrap_only();
      t_reset_shift();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule